// File: doc/BRIEF.md
# Four-Lane 5x5 Convolution Engine

This block filters a two-dimensional array of signed 16-bit samples with a 5x5 signed weight mask. Each output is the sum of 25 products around its centre. The array sits in external memory, stored one row after another. The engine reads it through a request/data port that returns four consecutive words of one row per beat. It produces four horizontally adjacent outputs at a time, using four multiply-accumulate lanes. Each group of four outputs takes 25 steps. In each step every lane receives the same weight, together with a sample taken at that lane's own horizontal offset. Weights are held in a local 25-entry bank. The 40 samples a group needs are held in one of two local sample banks. The next group is fetched into the other bank while the current group is being computed.

Software first writes the 25 weights through the weight-load pins while the engine is idle. It then presents the image height and width and pulses `start`. The engine emits results in raster order on a valid/ready stream, one 40-bit signed result per beat. If `res_ready` is low, the current beat is held unchanged and the engine stops working once its internal results cannot advance. No result is ever dropped. The request port follows the same rule: a pending request holds its address until it is accepted. Returned data must arrive in request order, at least one cycle after acceptance. The engine accepts each returned beat in the cycle it appears.

The image width minus 4 must be a multiple of 4, the width at least 8 and the height at least 5.

Top module: `conv4_engine`

## Requirements
- R1: Each result equals the sum, over vertical and horizontal offsets a and b from -2 to +2, of sample(row+a, col+b) times the weight at index (a+2)*5+(b+2). The result is computed in full precision as a 40-bit signed value, with no rounding or scaling.
- R2: Results exist only for 2 <= row <= height-3 and 2 <= col <= width-3. They leave in raster order: rows ascending, and within a row, columns ascending. Exactly that many results are produced per frame.
- R3: For each group of four results (row r, first column c), exactly 10 read requests are issued, and in this order. For rows r-2 to r+2, ascending, the engine requests (row, c-2) and then (row, c+2). Groups are requested in raster order. A returned beat for request (row, col) carries sample(row, col+w) in bits 16w+15 down to 16w, for w = 0 to 3.
- R4: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays valid and its row and column do not change.
- R5: While `res_valid` is high and `res_ready` is low, the result stays valid and its value does not change. No result is lost or repeated under any pattern on `res_ready`.
- R6: With `res_ready` and `rd_req_ready` held high and data returned one cycle after each request, consecutive groups of four results begin exactly 25 cycles apart.
- R7: A write on the weight-load pins with an index of 0 to 24, made while idle, sets that weight. Writes with an index of 25 or more have no effect, and neither do writes made while busy. Weights are kept across frames until they are rewritten.
- R8: `start` while idle latches the dimensions, and `busy` is high from the next cycle until the last result of the frame has been accepted. `start` while busy has no effect. While idle, neither `rd_req_valid` nor `res_valid` is high.
- R9: After reset, `busy`, `rd_req_valid` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (idle only) |
| img_rows | input | 12 | Image height in samples |
| img_cols | input | 12 | Image width in samples |
| busy | output | 1 | Frame in progress |
| wt_we | input | 1 | Weight write strobe |
| wt_idx | input | 5 | Weight index, (a+2)*5+(b+2) |
| wt_data | input | 16 | Signed weight value |
| rd_req_valid | output | 1 | Read request pending |
| rd_req_ready | input | 1 | Memory accepts request |
| rd_req_row | output | 12 | Row of requested beat |
| rd_req_col | output | 12 | First column of requested beat |
| rd_data_valid | input | 1 | Returned beat present |
| rd_data | input | 64 | Four 16-bit samples, lowest column in low bits |
| res_valid | output | 1 | Result beat valid |
| res_ready | input | 1 | Consumer accepts result |
| res_data | output | 40 | Signed filtered result |

## Verification
The assertions check the following on every cycle: that both valid/ready outputs hold steady under back-pressure; that returned data only ever lands in a bank with requests outstanding; that a sample bank is released only after it has been completely filled; that results move into the output stage only when it is empty; and that the engine is quiet while idle. The bench's scenarios are the only evidence for the arithmetic of each result, the set and order of results, the exact order of read requests, and the 25-cycle group spacing. They also show that weight writes made while busy or with an index out of range have no effect. Those scenarios cover full-scale sample and weight extremes, random stalls on every handshake, and a frame that runs without reloading its weights.

// File: rtl/conv4_pkg.sv
package conv4_pkg;
  localparam int LANES    = 4;
  localparam int TAPS     = 5;
  localparam int NCOEF    = TAPS * TAPS;
  localparam int SMP_W    = 16;
  localparam int ACC_W    = 40;
  localparam int DIM_W    = 12;
  localparam int HALO     = TAPS / 2;
  localparam int BUF_COLS = LANES + TAPS - 1;
  localparam int BPR      = (BUF_COLS + LANES - 1) / LANES;
  localparam int GRP_W    = 2 * DIM_W;
endpackage

// File: rtl/conv4_coef_bank.sv
module conv4_coef_bank
  import conv4_pkg::*;
#(
  parameter int N     = NCOEF,
  parameter int W     = SMP_W,
  parameter int IDX_W = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IDX_W-1:0]    widx,
  input  logic [W-1:0]        wdata,
  input  logic [IDX_W-1:0]    ridx,
  output logic signed [W-1:0] rdata
);
  logic signed [W-1:0] wt_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) wt_q[i] <= '0;
    end else if (we && (int'(widx) < N)) begin
      wt_q[widx] <= wdata;
    end
  end

  assign rdata = wt_q[ridx];
endmodule

// File: rtl/conv4_mac_lane.sv
module conv4_mac_lane
  import conv4_pkg::*;
#(
  parameter int W  = SMP_W,
  parameter int AW = ACC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 clr,
  input  logic signed [W-1:0]  smp,
  input  logic signed [W-1:0]  wt,
  output logic signed [AW-1:0] acc
);
  localparam int PW = 2 * W;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;
  logic signed [AW-1:0] base;

  assign prod     = smp * wt;
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
  assign base     = clr ? '0 : acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= base + prod_ext;
  end
endmodule

// File: rtl/conv4_fetch.sv
module conv4_fetch
  import conv4_pkg::*;
#(
  parameter int LN    = LANES,
  parameter int TP    = TAPS,
  parameter int W     = SMP_W,
  parameter int DW    = DIM_W,
  parameter int TAP_W = $clog2(TP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               active,
  input  logic [DW-1:0]      rows,
  input  logic [DW-1:0]      cols,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [DW-1:0]      rd_req_row,
  output logic [DW-1:0]      rd_req_col,
  input  logic               rd_data_valid,
  input  logic [LN*W-1:0]    rd_data,
  output logic               grp_ready,
  input  logic               rel,
  input  logic [TAP_W-1:0]   step_row,
  input  logic [TAP_W-1:0]   step_col,
  output logic [LN*W-1:0]    lane_smp
);
  localparam int HL     = TP / 2;
  localparam int BC     = LN + TP - 1;
  localparam int NB     = (BC + LN - 1) / LN;
  localparam int HALF_W = (NB > 1) ? $clog2(NB) : 1;
  localparam int EXT    = DW + 2;

  logic signed [W-1:0] sbuf [2][TP][NB*LN];
  logic [1:0]          claimed, full;
  logic                cb, q_bank, d_bank, req_done;
  logic [TAP_W-1:0]    q_row, d_row;
  logic [HALF_W-1:0]   q_half, d_half;
  logic [DW-1:0]       fr, fc;
  logic                acc_req, q_last, d_last;

  assign rd_req_valid = active && !req_done &&
                        ((q_row != '0) || (q_half != '0) || !claimed[q_bank]);
  assign acc_req      = rd_req_valid && rd_req_ready;
  assign q_last       = (int'(q_row) == TP-1) && (int'(q_half) == NB-1);
  assign d_last       = (int'(d_row) == TP-1) && (int'(d_half) == NB-1);
  assign rd_req_row   = fr - DW'(HL) + DW'(q_row);
  assign rd_req_col   = fc - DW'(HL) + DW'(q_half) * DW'(LN);
  assign grp_ready    = full[cb];

  // request sequencing and bank bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claimed <= '0; full <= '0; cb <= 1'b0; q_bank <= 1'b0; d_bank <= 1'b0;
      q_row <= '0; q_half <= '0; d_row <= '0; d_half <= '0;
      fr <= DW'(HL); fc <= DW'(HL); req_done <= 1'b0;
    end else if (init) begin
      claimed <= '0; full <= '0; cb <= 1'b0; q_bank <= 1'b0; d_bank <= 1'b0;
      q_row <= '0; q_half <= '0; d_row <= '0; d_half <= '0;
      fr <= DW'(HL); fc <= DW'(HL); req_done <= 1'b0;
    end else begin
      if (rel) begin
        full[cb]    <= 1'b0;
        claimed[cb] <= 1'b0;
        cb          <= ~cb;
      end
      if (acc_req) begin
        if ((q_row == '0) && (q_half == '0)) claimed[q_bank] <= 1'b1;
        if (q_last) begin
          q_row  <= '0;
          q_half <= '0;
          q_bank <= ~q_bank;
          if (EXT'(fc) + EXT'(2*LN + HL) <= EXT'(cols)) begin
            fc <= fc + DW'(LN);
          end else begin
            fc <= DW'(HL);
            if (EXT'(fr) + EXT'(HL + 2) <= EXT'(rows)) fr <= fr + 1'b1;
            else                                       req_done <= 1'b1;
          end
        end else if (int'(q_half) == NB-1) begin
          q_half <= '0;
          q_row  <= q_row + 1'b1;
        end else begin
          q_half <= q_half + 1'b1;
        end
      end
      if (rd_data_valid) begin
        if (d_last) begin
          d_row         <= '0;
          d_half        <= '0;
          full[d_bank]  <= 1'b1;
          d_bank        <= ~d_bank;
        end else if (int'(d_half) == NB-1) begin
          d_half <= '0;
          d_row  <= d_row + 1'b1;
        end else begin
          d_half <= d_half + 1'b1;
        end
      end
    end
  end

  // sample storage
  always_ff @(posedge clk) begin
    if (rd_data_valid) begin
      for (int w = 0; w < LN; w++)
        sbuf[d_bank][d_row][int'(d_half)*LN + w] <= rd_data[w*W +: W];
    end
  end

  for (genvar l = 0; l < LN; l++) begin : g_tap
    assign lane_smp[l*W +: W] = sbuf[cb][step_row][int'(step_col) + l];
  end

  // R3
  data_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_valid |-> (claimed[d_bank] && !full[d_bank]));
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=>
      (rd_req_valid && $stable(rd_req_row) && $stable(rd_req_col)));
  // R6
  rel_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel |-> full[cb]);
endmodule

// File: rtl/conv4_drain.sv
module conv4_drain
  import conv4_pkg::*;
#(
  parameter int LN = LANES,
  parameter int AW = ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LN*AW-1:0] res,
  output logic             empty,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [AW-1:0]    out_data
);
  localparam int CNT_W = $clog2(LN + 1);
  localparam int IDX_W = (LN > 1) ? $clog2(LN) : 1;

  logic [AW-1:0]    hold [LN];
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;

  assign empty     = (cnt == '0);
  assign out_valid = !empty;
  assign out_data  = hold[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      idx <= '0;
      for (int i = 0; i < LN; i++) hold[i] <= '0;
    end else if (load) begin
      cnt <= CNT_W'(LN);
      idx <= '0;
      for (int i = 0; i < LN; i++) hold[i] <= res[i*AW +: AW];
    end else if (out_valid && out_ready) begin
      cnt <= cnt - 1'b1;
      idx <= idx + 1'b1;
    end
  end

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R5
  load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt == '0));
  // R5
  drain_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= LN);
endmodule

// File: rtl/conv4_engine.sv
module conv4_engine
  import conv4_pkg::*;
#(
  parameter int LN = LANES,
  parameter int TP = TAPS,
  parameter int W  = SMP_W,
  parameter int AW = ACC_W,
  parameter int DW = DIM_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DW-1:0]        img_rows,
  input  logic [DW-1:0]        img_cols,
  output logic                 busy,
  input  logic                 wt_we,
  input  logic [$clog2(TP*TP)-1:0] wt_idx,
  input  logic [W-1:0]         wt_data,
  output logic                 rd_req_valid,
  input  logic                 rd_req_ready,
  output logic [DW-1:0]        rd_req_row,
  output logic [DW-1:0]        rd_req_col,
  input  logic                 rd_data_valid,
  input  logic [LN*W-1:0]      rd_data,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [AW-1:0]        res_data
);
  localparam int NC    = TP * TP;
  localparam int KS_W  = $clog2(NC);
  localparam int TAP_W = $clog2(TP);
  localparam int HL    = TP / 2;
  localparam int GW    = 2 * DW;

  logic [DW-1:0]        rows_q, cols_q;
  logic [GW-1:0]        total, done_cnt, total_nxt;
  logic [TAP_W-1:0]     sr, sc;
  logic [KS_W-1:0]      ks;
  logic                 fin, init, do_step, last, rel, load;
  logic                 grp_ready, drain_empty;
  logic [LN*W-1:0]      lane_smp;
  logic signed [W-1:0]  wt_cur;
  logic [LN*AW-1:0]     res_flat;

  assign init      = start && !busy;
  assign do_step   = busy && grp_ready && (!fin || drain_empty);
  assign last      = (int'(ks) == NC-1);
  assign rel       = do_step && last;
  assign load      = fin && drain_empty;
  assign total_nxt = GW'(img_rows - DW'(2*HL)) *
                     GW'((img_cols - DW'(2*HL)) / DW'(LN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; rows_q <= '0; cols_q <= '0; total <= '0; done_cnt <= '0;
      sr <= '0; sc <= '0; ks <= '0; fin <= 1'b0;
    end else if (init) begin
      busy <= 1'b1; rows_q <= img_rows; cols_q <= img_cols; total <= total_nxt;
      done_cnt <= '0; sr <= '0; sc <= '0; ks <= '0; fin <= 1'b0;
    end else begin
      if (do_step) begin
        if (last) begin
          ks <= '0; sr <= '0; sc <= '0;
        end else begin
          ks <= ks + 1'b1;
          if (int'(sc) == TP-1) begin
            sc <= '0;
            sr <= sr + 1'b1;
          end else begin
            sc <= sc + 1'b1;
          end
        end
      end
      if (load) begin
        fin      <= 1'b0;
        done_cnt <= done_cnt + 1'b1;
      end
      if (rel) fin <= 1'b1;
      if (busy && !fin && drain_empty && (done_cnt == total)) busy <= 1'b0;
    end
  end

  conv4_coef_bank #(.N(NC), .W(W), .IDX_W(KS_W)) u_wts (
    .clk(clk), .rst_n(rst_n), .we(wt_we && !busy), .widx(wt_idx),
    .wdata(wt_data), .ridx(ks), .rdata(wt_cur)
  );

  conv4_fetch #(.LN(LN), .TP(TP), .W(W), .DW(DW), .TAP_W(TAP_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .init(init), .active(busy),
    .rows(rows_q), .cols(cols_q),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_row(rd_req_row), .rd_req_col(rd_req_col),
    .rd_data_valid(rd_data_valid), .rd_data(rd_data),
    .grp_ready(grp_ready), .rel(rel), .step_row(sr), .step_col(sc),
    .lane_smp(lane_smp)
  );

  for (genvar l = 0; l < LN; l++) begin : g_lane
    logic signed [AW-1:0] acc_l;
    conv4_mac_lane #(.W(W), .AW(AW)) u_mac (
      .clk(clk), .rst_n(rst_n), .en(do_step), .clr(ks == '0),
      .smp(lane_smp[l*W +: W]), .wt(wt_cur), .acc(acc_l)
    );
    assign res_flat[l*AW +: AW] = acc_l;
  end

  conv4_drain #(.LN(LN), .AW(AW)) u_drain (
    .clk(clk), .rst_n(rst_n), .load(load), .res(res_flat),
    .empty(drain_empty), .out_valid(res_valid), .out_ready(res_ready),
    .out_data(res_data)
  );

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!res_valid && !rd_req_valid));
  // R2
  grp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (done_cnt <= total));
endmodule

// File: tb/conv4_engine_tb_top.sv
module conv4_engine_tb_top;
  import conv4_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [DIM_W-1:0] img_rows = '0, img_cols = '0;
  logic             busy;
  logic             wt_we = 1'b0;
  logic [4:0]       wt_idx = '0;
  logic [15:0]      wt_data = '0;
  logic             rd_req_valid, rd_req_ready = 1'b0;
  logic [DIM_W-1:0] rd_req_row, rd_req_col;
  logic             rd_data_valid = 1'b0;
  logic [63:0]      rd_data = '0;
  logic             res_valid, res_ready = 1'b0;
  logic [ACC_W-1:0] res_data;

  int    errors = 0, checks = 0, cyc = 0;
  int    img [16][16];
  int    wts [25];
  longint exp_q[$];
  int    req_q[$];
  int    pipe_q[$];
  bit    rand_out = 0, rand_req = 0, rand_lat = 0, fast_mode = 0;
  int    beat_cnt = 0, grp_first = 0;
  bit    req_wait = 0, out_wait = 0;
  logic [DIM_W-1:0] held_row, held_col;
  logic [ACC_W-1:0] held_res;

  always #5 clk = ~clk;

  conv4_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .img_rows(img_rows),
    .img_cols(img_cols), .busy(busy), .wt_we(wt_we), .wt_idx(wt_idx),
    .wt_data(wt_data), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_row(rd_req_row), .rd_req_col(rd_req_col),
    .rd_data_valid(rd_data_valid), .rd_data(rd_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model, handshakes and reference comparison, every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (pipe_q.size() > 0 && (!rand_lat || $urandom_range(0, 1) == 1)) begin
        int e, r, c;
        e = pipe_q.pop_front();
        r = e >> 16; c = e & 16'hffff;
        for (int w = 0; w < 4; w++) rd_data[w*16 +: 16] = 16'(img[r][c+w]);
        rd_data_valid = 1'b1;
      end else begin
        rd_data_valid = 1'b0;
      end
      if (req_wait)  // R4
        check(rd_req_valid && rd_req_row == held_row && rd_req_col == held_col,
              "R4 request held", {rd_req_row, rd_req_col}, {held_row, held_col});
      if (out_wait)  // R5
        check(res_valid && res_data == held_res, "R5 result held",
              longint'(res_data), longint'(held_res));
      rd_req_ready = rand_req ? 1'($urandom_range(0, 1)) : 1'b1;
      res_ready    = rand_out ? 1'($urandom_range(0, 1)) : 1'b1;
      req_wait = rd_req_valid && !rd_req_ready;
      out_wait = res_valid && !res_ready;
      held_row = rd_req_row; held_col = rd_req_col; held_res = res_data;
      if (rd_req_valid && rd_req_ready) begin
        int got;
        got = (int'(rd_req_row) << 16) | int'(rd_req_col);
        if (req_q.size() == 0) check(0, "R3 unexpected request", got, -1);
        else begin
          int e;
          e = req_q.pop_front();
          check(got == e, "R3 request order", got, e);
        end
        pipe_q.push_back(got);
      end
      if (res_valid && res_ready) begin
        longint act;
        act = longint'($signed(res_data));
        if (exp_q.size() == 0) check(0, "R2 extra result", act, 0);
        else begin
          longint e;
          e = exp_q.pop_front();
          check(act == e, "R1 result value", act, e);
        end
        if (beat_cnt % 4 == 0) begin
          if (fast_mode && beat_cnt > 0)  // R6
            check(cyc - grp_first == 25, "R6 group spacing", cyc - grp_first, 25);
          grp_first = cyc;
        end
        beat_cnt++;
      end
    end
  end

  task automatic load_weights();
    for (int i = 0; i < 25; i++) begin
      @(negedge clk); wt_we = 1'b1; wt_idx = 5'(i); wt_data = 16'(wts[i]);
    end
    @(negedge clk); wt_we = 1'b0;
  endtask

  task automatic build_expect(int rows, int cols);
    for (int r = 2; r <= rows - 3; r++)
      for (int c = 2; c <= cols - 3; c++) begin
        longint s = 0;
        for (int a = -2; a <= 2; a++)
          for (int b = -2; b <= 2; b++)
            s += longint'(img[r+a][c+b]) * longint'(wts[(a+2)*5 + (b+2)]);
        exp_q.push_back(s);
      end
    for (int r = 2; r <= rows - 3; r++)
      for (int c = 2; c + 3 <= cols - 3; c += 4)
        for (int k = 0; k < 5; k++)
          for (int h = 0; h < 2; h++)
            req_q.push_back(((r - 2 + k) << 16) | (c - 2 + 4*h));
  endtask

  task automatic run_frame(int rows, int cols, bit disturb);
    build_expect(rows, cols);
    beat_cnt = 0;
    @(negedge clk); img_rows = DIM_W'(rows); img_cols = DIM_W'(cols); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R8 busy after start", busy, 1);
    if (disturb) begin
      repeat (30) @(negedge clk);
      // R7: weight write while busy must be ignored; R8: start while busy ignored
      wt_we = 1'b1; wt_idx = 5'd12; wt_data = 16'h1234;
      start = 1'b1; img_rows = 5; img_cols = 8;
      @(negedge clk); wt_we = 1'b0; start = 1'b0;
    end
    while (busy) @(negedge clk);
    check(exp_q.size() == 0, "R2 result count", exp_q.size(), 0);
    check(req_q.size() == 0, "R3 request count", req_q.size(), 0);
    check(!res_valid && !rd_req_valid, "R8 idle quiet", {res_valid, rd_req_valid}, 0);
  endtask

  task automatic fill_random(int rows, int cols);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++) img[r][c] = int'($urandom_range(0, 65535)) - 32768;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!busy, "R9 busy low", busy, 0);
    check(!rd_req_valid, "R9 request low", rd_req_valid, 0);
    check(!res_valid, "R9 result low", res_valid, 0);

    // Frame A: full speed, throughput (R6), random values (R1)
    for (int i = 0; i < 25; i++) wts[i] = int'($urandom_range(0, 65535)) - 32768;
    load_weights();
    // R7: out-of-range indices ignored
    for (int i = 25; i < 32; i++) begin
      @(negedge clk); wt_we = 1'b1; wt_idx = 5'(i); wt_data = 16'h7fff;
    end
    @(negedge clk); wt_we = 1'b0;
    fill_random(8, 16);
    fast_mode = 1;
    run_frame(8, 16, 0);
    fast_mode = 0;

    // Frame B: random stalls everywhere, writes and start while busy (R4 R5 R7 R8)
    rand_out = 1; rand_req = 1; rand_lat = 1;
    for (int i = 0; i < 25; i++) wts[i] = int'($urandom_range(0, 511)) - 256;
    load_weights();
    fill_random(11, 12);
    run_frame(11, 12, 1);

    // Frame C: smallest image, full-scale extremes (R1 precision)
    rand_out = 0; rand_req = 0; rand_lat = 0;
    for (int i = 0; i < 25; i++) wts[i] = -32768;
    load_weights();
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 8; c++) img[r][c] = -32768;
    run_frame(5, 8, 0);
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 8; c++) img[r][c] = 32767;
    run_frame(5, 8, 0);

    // Frame D: weights retained without reload (R7), back-pressure on results
    rand_out = 1;
    fill_random(9, 8);
    run_frame(9, 8, 0);
    rand_out = 0;

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule